// File: doc/BRIEF.md
# Entropy Key Gatherer

This block builds wide cryptographic keys out of a raw one-bit random stream, such as the sampled output of an on-chip noise source. Each clock cycle one bit per lane enters a serial-in shift register. A fill counter tracks how far the current key has progressed. When the fill completes, the assembled word is copied into an output key register and a ready flag is raised.

A consumer takes the key by pulsing a read strobe while the flag is high. The strobe clears the flag. Collection never pauses: the counter wraps after every completion and gathering starts again at once. So the key register is refreshed at every completion, and a fresh key is ready without delay whenever enough cycles have passed since the last read.

A build parameter splits the key into two lanes, each fed by its own entropy input. Each lane fills half the key, which halves the time to complete a key.

Top module: `entropy_key_gather`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the fill counter, the shift registers, the key register (`key_out` = 0) and the ready flag (`key_ready` = 0).
- R2: Every lane takes in one bit per clock cycle. After reset is released, `key_ready` first rises after exactly KEY_W/LANES rising edges. With the defaults (KEY_W = 128, LANES = 1) that is 128 edges.
- R3: With one lane, the first bit taken after a completion lands in `key_out[KEY_W-1]` and the last bit lands in `key_out[0]`. The bit taken at the k-th edge of a fill sits at bit KEY_W-1-k.
- R4: With two lanes, `ent_bits[0]` fills the upper half and `ent_bits[1]` fills the lower half. The first bit of lane 0 goes to bit KEY_W-1 and the first bit of lane 1 goes to bit KEY_W/2-1. A key completes in KEY_W/2 cycles.
- R5: `key_out` changes only at the edge that ends a fill. It holds its value at every other edge.
- R6: A read strobe at an edge where `key_ready` is high and no fill ends clears `key_ready` after that edge. The flag then stays low until the next fill completes.
- R7: When a read strobe and a fill completion fall on the same edge, the completion wins. `key_ready` stays high and `key_out` takes the new key.
- R8: Collection goes on without any read. Every KEY_W/LANES cycles the key register is reloaded with the bits of the latest fill, and `key_ready` stays set.
- R9: A read strobe while `key_ready` is low has no effect. The flag stays low and `key_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ent_bits | input | LANES | One sampled random bit per lane per cycle |
| key_rd | input | 1 | Read strobe; consumes the presented key |
| key_out | output | KEY_W | Most recently completed key |
| key_ready | output | 1 | High while an unread key is held |

## Verification
The flag and the key are registered outputs. A completion becomes visible right after the edge that takes the last bit of a fill: edge KEY_W/LANES-1 after reset release, counted from zero. A read strobe shows its effect right after the edge at which it was sampled. The bench drives every input on the falling edge and reads the outputs on the next falling edge, so each check compares against a value computed for a known count of elapsed rising edges. Expected keys are assembled in the bench from the same bit sequence it drives, placed by arithmetic on the edge index.

// File: rtl/entropy_key_gather_pkg.sv
package entropy_key_gather_pkg;

  // Width of one lane's shift register for a given key width and lane count.
  function automatic int unsigned lane_width(input int unsigned key_w,
                                             input int unsigned lanes);
    return key_w / lanes;
  endfunction

  // Counter width needed to count 0 .. lane_w-1 (at least one bit).
  function automatic int unsigned count_width(input int unsigned lane_w);
    return (lane_w > 2) ? $clog2(lane_w) : 1;
  endfunction

  // Position of the most significant key bit owned by lane idx.
  function automatic int unsigned lane_top(input int unsigned key_w,
                                           input int unsigned lane_w,
                                           input int unsigned idx);
    return key_w - 1 - idx * lane_w;
  endfunction

endpackage

// File: rtl/kg_lane_shift.sv
module kg_lane_shift #(
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  output logic [WIDTH-1:0] word_next
);

  logic [WIDTH-1:0] word_q;

  // The oldest bit moves toward the MSB; the newest enters at bit 0.
  assign word_next = {word_q[WIDTH-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else begin
      word_q <= word_next;
    end
  end

endmodule

// File: rtl/kg_fill_counter.sv
module kg_fill_counter #(
  parameter int unsigned LANE_W = 128,
  parameter int unsigned CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_q,
  output logic             fill_done
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LANE_W - 1);

  assign fill_done = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (fill_done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/kg_key_hold.sv
module kg_key_hold #(
  parameter int unsigned KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [KEY_W-1:0] next_key,
  input  logic             rd,
  output logic [KEY_W-1:0] key_q,
  output logic             ready_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q   <= '0;
      ready_q <= 1'b0;
    end else if (load) begin
      // A completion takes priority over a read in the same cycle.
      key_q   <= next_key;
      ready_q <= 1'b1;
    end else if (rd) begin
      ready_q <= 1'b0;
    end
  end

endmodule

// File: rtl/entropy_key_gather.sv
module entropy_key_gather
  import entropy_key_gather_pkg::*;
#(
  parameter int unsigned KEY_W = 128,
  parameter int unsigned LANES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] ent_bits,
  input  logic             key_rd,
  output logic [KEY_W-1:0] key_out,
  output logic             key_ready
);

  localparam int unsigned LANE_W = lane_width(KEY_W, LANES);
  localparam int unsigned CNT_W  = count_width(LANE_W);

  // Named internal events, brought out for the checker.
  logic [CNT_W-1:0] fill_cnt;
  logic             fill_done;
  logic [KEY_W-1:0] assembled_key;

  kg_fill_counter #(
    .LANE_W (LANE_W),
    .CNT_W  (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .cnt_q     (fill_cnt),
    .fill_done (fill_done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned TOP = lane_top(KEY_W, LANE_W, g);
    logic [LANE_W-1:0] lane_word;

    kg_lane_shift #(
      .WIDTH (LANE_W)
    ) u_sr (
      .clk       (clk),
      .rst       (rst),
      .bit_in    (ent_bits[g]),
      .word_next (lane_word)
    );

    assign assembled_key[TOP -: LANE_W] = lane_word;
  end

  kg_key_hold #(
    .KEY_W (KEY_W)
  ) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load     (fill_done),
    .next_key (assembled_key),
    .rd       (key_rd),
    .key_q    (key_out),
    .ready_q  (key_ready)
  );

endmodule

// File: rtl/kg_checker.sv
module kg_checker #(
  parameter int unsigned KEY_W  = 128,
  parameter int unsigned LANE_W = 128,
  parameter int unsigned CNT_W  = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             key_rd,
  input logic             key_ready,
  input logic [KEY_W-1:0] key_out,
  input logic             fill_done,
  input logic [CNT_W-1:0] fill_cnt
);

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CNT_W'(LANE_W - 1));

  // R8
  cnt_wraps_chk: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> (fill_cnt == '0));

  // R5
  key_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !fill_done |=> $stable(key_out));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (key_ready && key_rd && !fill_done) |=> !key_ready);

  // R7
  completion_sets_chk: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> key_ready);

  // R9
  no_spurious_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !fill_done |=> !$rose(key_ready));

endmodule

bind entropy_key_gather kg_checker #(
  .KEY_W  (KEY_W),
  .LANE_W (LANE_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .key_rd    (key_rd),
  .key_ready (key_ready),
  .key_out   (key_out),
  .fill_done (fill_done),
  .fill_cnt  (fill_cnt)
);

// File: tb/sim_entropy_key_gather.sv
module sim_entropy_key_gather;

  localparam int CLK_PERIOD = 10;
  localparam int KW = 128;

  logic          clk = 1'b0;
  logic          rst;
  logic          ent0;
  logic [1:0]    ent1;
  logic          rd0, rd1;
  logic [KW-1:0] key0, key1;
  logic          ready0, ready1;

  int n = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  entropy_key_gather #(.KEY_W(KW), .LANES(1)) u0 (
    .clk(clk), .rst(rst), .ent_bits(ent0), .key_rd(rd0),
    .key_out(key0), .key_ready(ready0));

  entropy_key_gather #(.KEY_W(KW), .LANES(2)) u1 (
    .clk(clk), .rst(rst), .ent_bits(ent1), .key_rd(rd1),
    .key_out(key1), .key_ready(ready1));

  function automatic logic bit_a(input int idx);
    logic [31:0] h;
    h = 32'(idx) * 32'h9E37_79B1 + 32'h0000_0B17;
    return h[16] ^ h[5];
  endfunction

  function automatic logic bit_b(input int idx);
    logic [31:0] h;
    h = 32'(idx) * 32'h85EB_CA6B + 32'h0000_3C5D;
    return ~(h[21] ^ h[9]);
  endfunction

  // Single lane: bit of edge start+i sits at KW-1-i.
  function automatic logic [KW-1:0] exp_one(input int start);
    logic [KW-1:0] k;
    k = '0;
    for (int i = 0; i < KW; i++) k[KW-1-i] = bit_a(start + i);
    return k;
  endfunction

  // Two lanes: lane 0 in the upper half, lane 1 in the lower half.
  function automatic logic [KW-1:0] exp_dual(input int start);
    logic [KW-1:0] k;
    k = '0;
    for (int i = 0; i < KW/2; i++) begin
      k[KW-1-i]   = bit_a(start + i);
      k[KW/2-1-i] = bit_b(start + i);
    end
    return k;
  endfunction

  task automatic drive();
    ent0 = bit_a(n);
    ent1 = {bit_b(n), bit_a(n)};
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    n = n + 1;
    drive();
  endtask

  task automatic chk(input string req, input logic [KW-1:0] act,
                     input logic [KW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at n=%0d: actual=%h expected=%h", req, n, act, exp);
    end
  endtask

  initial begin
    rst = 1'b1; rd0 = 1'b0; rd1 = 1'b0;
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 key0", key0, '0);
    chk("R1 ready0", KW'(ready0), '0);
    chk("R1 key1", key1, '0);
    chk("R1 ready1", KW'(ready1), '0);
    rst = 1'b0;
    n = 0;
    drive();

    // R2 / R4: exact edge at which ready first rises
    for (int t = 1; t <= KW; t++) begin
      tick();
      chk("R2 ready0", KW'(ready0), KW'(t >= KW));
      chk("R4 ready1", KW'(ready1), KW'(t >= KW/2));
      if (t == KW/2) chk("R4 key1", key1, exp_dual(0));
      if (t == 100)  chk("R5 key1 hold", key1, exp_dual(0));
    end
    chk("R3 key0 order", key0, exp_one(0));
    chk("R8 key1 refresh", key1, exp_dual(64));
    chk("R8 ready1", KW'(ready1), KW'(1));

    // R6: read at a non-completion edge
    rd0 = 1'b1; rd1 = 1'b1;
    tick();
    rd1 = 1'b0;
    chk("R6 ready0", KW'(ready0), '0);
    chk("R6 key0", key0, exp_one(0));
    chk("R6 ready1", KW'(ready1), '0);

    // rd0 held high while flag low (R9), then through a completion (R7)
    while (n < 256) begin
      tick();
      if (n == 192) begin
        chk("R6 ready1 back", KW'(ready1), KW'(1));
        chk("R8 key1", key1, exp_dual(128));
      end
      if (n == 200) begin
        chk("R9 ready0", KW'(ready0), '0);
        chk("R9 key0", key0, exp_one(0));
      end
      if (n == 255) chk("R6 ready0 low", KW'(ready0), '0);
    end
    chk("R7 ready0", KW'(ready0), KW'(1));
    chk("R7 key0", key0, exp_one(128));
    rd0 = 1'b0;

    // R7 with ready already high: read exactly on the completion edge
    while (n < 383) tick();
    chk("R8 ready0 held", KW'(ready0), KW'(1));
    chk("R5 key0 hold", key0, exp_one(128));
    rd0 = 1'b1;
    tick();
    chk("R7 ready0 keep", KW'(ready0), KW'(1));
    chk("R7 key0 new", key0, exp_one(256));
    tick();
    rd0 = 1'b0;
    chk("R6 ready0 cleared", KW'(ready0), '0);
    chk("R6 key0 kept", key0, exp_one(256));
    chk("R8 key1 late", key1, exp_dual(320));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule